// File: doc/BRIEF.md
# UART Baud Rate Generator

This block turns the system clock into the two timing strobes a UART needs. One is an oversample strobe for the receiver, at sixteen pulses per bit. The other is a bit strobe for the transmitter. Both are one-clock pulses. A 16-bit period value sets the rate. A width select decides whether only the low byte of that value counts or the whole word. A speed select decides whether each oversample strobe spans one counter period or four. This gives sixteen or sixty-four clocks per counter period for each bit.

With the speed select set, the bit rate is f_clk / (16·(P+1)). With it clear, the bit rate is f_clk / (64·(P+1)). For example, a 10 MHz clock with P = 64 in fast mode gives one bit every 1040 clocks, about 9615 baud. Any change to the effective period or to either select restarts the division chain from the new value at once. The bit phase therefore always lines up with the latest configuration.

Top module: `uart_baud_gen`

## Requirements
- R1: While reset is held, and on the first clock after it is released, both strobes are low.
- R2: With the speed select high, the oversample strobe repeats every P+1 clocks.
- R3: With the speed select low, the oversample strobe repeats every 4·(P+1) clocks, and it is never high on two consecutive clocks.
- R4: Each bit-strobe period contains exactly 16 oversample strobes. The bit strobe is high in the same cycle as the 16th of them.
- R5: With the width select low, only bits 7:0 of the period are used. Changing bits 15:8 neither alters the rate nor restarts the count.
- R6: With the width select high, all 16 bits of the period set the rate.
- R7: When the effective period or either select changes, the count restarts at once. Take the first rising edge that sees the new value as edge 1. The first oversample strobe is then high after edge M·(P+1)+1, and the first bit strobe after edge 16·M·(P+1)+1, where M is 1 in fast mode and 4 in slow mode.
- R8: With P = 0 in fast mode, the oversample strobe is high on every clock and the bit strobe on every 16th clock.
- R9: The bit strobe is never high for two consecutive clocks. The internal down-counter never exceeds the stored period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_val | input | 16 | Period value P |
| wide_en | input | 1 | 1: use all 16 bits of P; 0: use bits 7:0 only |
| fast_en | input | 1 | 1: 16 clocks per counter period per bit; 0: 64 |
| os_tick | output | 1 | One-cycle oversample strobe (16 per bit) |
| bit_tick | output | 1 | One-cycle bit-rate strobe |

## Verification
The bench sweeps the low periods 0 to 5 in both speed modes. For each one it checks the latency to the first strobe, the spacing between strobes and the number of oversample strobes per bit. This separates a wrong reload value from a wrong slow-mode prescale from a wrong oversample count.

Further cases cover the rest:
- Wide periods above 255 show that the high byte takes effect in 16-bit mode.
- A non-zero high byte in 8-bit mode shows that the high byte is masked.
- A high-byte change made mid-run must leave the strobe spacing untouched.
- A period change made mid-count must shorten the next interval to the new restart latency.

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int PER_W     = 16,
  parameter int LOW_W     = 8,
  parameter int OS_RATIO  = 16,
  parameter int SLOW_MULT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_val,
  input  logic             wide_en,
  input  logic             fast_en,
  output logic             os_tick,
  output logic             bit_tick
);

  localparam int OS_W  = (OS_RATIO > 1) ? $clog2(OS_RATIO) : 1;
  localparam int PRE_W = (SLOW_MULT > 1) ? $clog2(SLOW_MULT) : 1;
  localparam logic [OS_W-1:0]  OS_LAST  = OS_W'(OS_RATIO - 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SLOW_MULT - 1);

  logic [PER_W-1:0] p_eff, per_q, cnt;
  logic [PRE_W-1:0] pre;
  logic [OS_W-1:0]  os_cnt;
  logic             run_q, wide_q, fast_q;
  logic             restart, base_hit, pre_done, os_hit, bit_hit;

  assign p_eff    = wide_en ? period_val
                            : {{(PER_W-LOW_W){1'b0}}, period_val[LOW_W-1:0]};
  assign restart  = !run_q || (p_eff != per_q) || (wide_en != wide_q) || (fast_en != fast_q);
  assign base_hit = (cnt == '0) && !restart;
  assign pre_done = fast_q || (pre == PRE_LAST);
  assign os_hit   = base_hit && pre_done;
  assign bit_hit  = os_hit && (os_cnt == OS_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      per_q    <= '0;
      wide_q   <= 1'b0;
      fast_q   <= 1'b0;
      cnt      <= '0;
      pre      <= '0;
      os_cnt   <= '0;
      os_tick  <= 1'b0;
      bit_tick <= 1'b0;
    end else begin
      run_q    <= 1'b1;
      per_q    <= p_eff;
      wide_q   <= wide_en;
      fast_q   <= fast_en;
      os_tick  <= os_hit;
      bit_tick <= bit_hit;
      if (restart) begin
        cnt    <= p_eff;
        pre    <= '0;
        os_cnt <= '0;
      end else if (base_hit) begin
        cnt <= per_q;
        pre <= pre_done ? '0 : pre + 1'b1;
        if (os_hit)
          os_cnt <= (os_cnt == OS_LAST) ? '0 : os_cnt + 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_BIT_ON_OS: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);  // R4
  AST_BIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);  // R9
  AST_QUIET_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!os_tick && !bit_tick));  // R7
  AST_SLOW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && !fast_q && run_q && !restart) |=> !os_tick);  // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt <= per_q));  // R9

endmodule

// File: tb/uart_baud_gen_tb.sv
module uart_baud_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] period_val = '0;
  logic        wide_en = 1'b0;
  logic        fast_en = 1'b0;
  logic        os_tick, bit_tick;
  int          n_chk = 0, n_fail = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  uart_baud_gen dut_i (
    .clk(clk), .rst_n(rst_n), .period_val(period_val),
    .wide_en(wide_en), .fast_en(fast_en),
    .os_tick(os_tick), .bit_tick(bit_tick)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_cfg(input logic [15:0] p, input logic w, input logic f,
                         input longint peff, input string rate_req);
    longint m, per, n, first, second, bitn, oscount, bit_on_os;
    m = f ? 1 : 4;
    per = m * (peff + 1);
    n = 0; first = 0; second = 0; bitn = 0; oscount = 0; bit_on_os = 0;
    @(negedge clk);
    period_val = p; wide_en = w; fast_en = f;
    while (bitn == 0 && n < 16 * per + 20) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (os_tick) begin
        oscount++;
        if (first == 0) first = n;
        else if (second == 0) second = n;
      end
      if (bit_tick) begin
        bitn = n;
        bit_on_os = os_tick;
      end
    end
    check("R7 first os latency", first, per + 1);
    check({rate_req, " os spacing"}, second - first, per);
    check("R7 first bit latency", bitn, 16 * per + 1);
    check("R4 os per bit", oscount, 16);
    check("R4 bit aligned to os", bit_on_os, 1);
    @(negedge clk);
    check("R9 bit one cycle", bit_tick, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    longint n;
    repeat (3) @(negedge clk);
    check("R1 os in reset", os_tick, 0);
    check("R1 bit in reset", bit_tick, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 os after release", os_tick, 0);
    check("R1 bit after release", bit_tick, 0);

    for (int p = 0; p < 6; p++)
      for (int f = 1; f >= 0; f--)
        run_cfg(16'(p), 1'b0, f[0], p, f ? "R2" : "R3");

    run_cfg(16'h0000, 1'b0, 1'b1, 0, "R2");
    @(negedge clk);
    check("R8 os every clock", os_tick, 1);

    run_cfg(16'hA703, 1'b0, 1'b1, 3, "R5");
    run_cfg(16'h0102, 1'b1, 1'b1, 258, "R6");
    run_cfg(16'h0101, 1'b1, 1'b0, 257, "R6");
    run_cfg(16'd64, 1'b0, 1'b1, 64, "R2");

    run_cfg(16'd4, 1'b0, 1'b1, 4, "R2");
    do @(negedge clk); while (!os_tick);
    period_val = 16'h5504;
    n = 0;
    do begin @(negedge clk); n++; end while (!os_tick && n < 100);
    check("R5 high byte change ignored", n, 5);

    run_cfg(16'd7, 1'b0, 1'b1, 7, "R2");
    do @(negedge clk); while (!os_tick);
    repeat (3) @(negedge clk);
    period_val = 16'd2;
    n = 0;
    do begin @(negedge clk); n++; end while (!os_tick && n < 100);
    check("R7 mid-count restart", n, 4);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule